// File: doc/BRIEF.md
# Grid Video Timing Generator

This block produces the raster timing and pixel colour for a fixed grid-line test picture on a VGA-style display. It runs entirely on the system clock. A small divider raises a one-cycle pixel enable once every four clocks. A column counter and a line counter step only on that enable. Two active-low sync pulses and an 8-bit colour are decoded from the current counter pair. Nothing is stored per pixel: each colour is worked out from the counters while the beam passes.

The picture has four ingredients, tested in a fixed order of precedence. The first visible column is painted one colour. The second line gets another colour. The last visible column gets a third colour. Every other visible pixel takes a fill colour. Pixels outside the visible window are driven black, so the sync intervals carry no colour.

Colour and both syncs leave the block through one register stage, so the three outputs always describe the same pixel. Every width, count and colour code is a parameter. The defaults give an 800 by 525 raster with a 640 by 480 visible area.

Top module: `grid_video_timing`

## Requirements
- R1: The pixel enable is high for exactly one clock in every DIV clocks (default 4). The column and line counters change only on clocks where the enable is high.
- R2: The column counts from 1 to H_TOTAL (default 800). After H_TOTAL it returns to 1 and the line advances by one, so one line lasts H_TOTAL*DIV clocks.
- R3: The line counts from 1 to V_TOTAL (default 525). After the last column of line V_TOTAL, both counters return to 1, so one frame lasts H_TOTAL*V_TOTAL*DIV clocks.
- R4: hsync_n is 0 for columns HS_START to HS_START+HS_LEN-1 (default 656 to 751, which is 96 pixels) and 1 elsewhere.
- R5: vsync_n is 0 for lines VS_START to VS_START+VS_LEN-1 (default 491 and 492) and 1 elsewhere.
- R6: Inside the visible window the colour is chosen in this order of precedence: 0x38 at column 1; otherwise 0xE5 at line 2; otherwise 0x07 at column H_VIS (default 640); otherwise 0xCD.
- R7: The colour is 0x00 whenever the column is above H_VIS or the line is above V_VIS (default visible window: columns 1 to 640, lines 1 to 480).
- R8: The three outputs are registered and show the counter state of the previous clock. A synchronous reset sets both counters to 1, clears the divider, and drives the colour to 0x00 and both syncs to 1. After reset is released, the first counter step happens on the DIV-th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_colour | output | 8 | Registered 8-bit pixel colour |
| hsync_n | output | 1 | Registered horizontal sync, active low |
| vsync_n | output | 1 | Registered vertical sync, active low |

## Verification
A reduced raster of 20 by 12 positions is swept over many whole frames, clock by clock. Every pixel, both sync windows, the visible edges and both wraps are compared against an arithmetic model of the counters and the divider phase. This tells apart errors in colour precedence, blanking, sync placement and counter wrap. A second instance at the full default raster runs for about eighteen lines. It confirms the real column 640 marker, the line 2 band and the 96-pixel horizontal pulse. Pulse widths and the periods between sync edges are also measured. A reset applied in the middle of a frame checks the return to the origin and the phase of the divider.

// File: rtl/grid_pkg.sv
package grid_pkg;

   localparam int unsigned CLR_W = 8;

   typedef logic [CLR_W-1:0] grid_colour_t;

   // true when pos lies in [lo, lo+len-1]
   function automatic logic in_span(input int unsigned pos,
                                    input int unsigned lo,
                                    input int unsigned len);
      return (pos >= lo) && (pos < lo + len);
   endfunction

   function automatic int unsigned bits_for(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/grid_pace_div.sv
module grid_pace_div #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic en_o
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("grid_pace_div: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_every_clock
         logic unused_ok;
         assign unused_ok = clk ^ rst;
         assign en_o      = 1'b1;
      end else begin : g_divided
         localparam int unsigned DW = grid_pkg::bits_for(DIV - 1);
         localparam logic [DW-1:0] LAST = DW'(DIV - 1);

         logic [DW-1:0] phase_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               phase_q <= '0;
            end else if (phase_q == LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + DW'(1);
            end
         end

         assign en_o = (phase_q == LAST);

         // enable never lasts two clocks in a row
         p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
            en_o |=> !en_o);

         // after reset release the enable stays low until the phase count is used up
         p_first_wait_r1: assert property (@(posedge clk)
            rst |=> !en_o);
      end
   endgenerate

endmodule

// File: rtl/grid_raster_cnt.sv
module grid_raster_cnt #(
   parameter int unsigned H_TOTAL = 800,
   parameter int unsigned V_TOTAL = 525,
   parameter int unsigned COL_W   = 10,
   parameter int unsigned ROW_W   = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,
   output logic [COL_W-1:0] col_o,
   output logic [ROW_W-1:0] row_o
);

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_TOTAL);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_TOTAL);
   localparam logic [COL_W-1:0] COL_ONE  = COL_W'(1);
   localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);

   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;
   logic             line_end;
   logic             frame_end;

   assign line_end  = (col_q == COL_LAST);
   assign frame_end = line_end && (row_q == ROW_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         col_q <= COL_ONE;
         row_q <= ROW_ONE;
      end else if (en_i) begin
         if (line_end) begin
            col_q <= COL_ONE;
            if (frame_end) begin
               row_q <= ROW_ONE;
            end else begin
               row_q <= row_q + ROW_ONE;
            end
         end else begin
            col_q <= col_q + COL_ONE;
         end
      end
   end

   assign col_o = col_q;
   assign row_o = row_q;

   // position frozen between enables
   p_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> ($stable(col_q) && $stable(row_q)));

   p_col_span_r2: assert property (@(posedge clk) disable iff (rst)
      (col_q >= COL_ONE) && (col_q <= COL_LAST));

   p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
      (en_i && (col_q != COL_LAST)) |=>
         ((col_q == $past(col_q) + COL_ONE) && $stable(row_q)));

   p_line_step_r2: assert property (@(posedge clk) disable iff (rst)
      (en_i && (col_q == COL_LAST) && (row_q != ROW_LAST)) |=>
         ((col_q == COL_ONE) && (row_q == $past(row_q) + ROW_ONE)));

   p_row_span_r3: assert property (@(posedge clk) disable iff (rst)
      (row_q >= ROW_ONE) && (row_q <= ROW_LAST));

   p_frame_wrap_r3: assert property (@(posedge clk) disable iff (rst)
      (en_i && (col_q == COL_LAST) && (row_q == ROW_LAST)) |=>
         ((col_q == COL_ONE) && (row_q == ROW_ONE)));

endmodule

// File: rtl/grid_paint.sv
module grid_paint
   import grid_pkg::*;
#(
   parameter int unsigned  H_VIS    = 640,
   parameter int unsigned  V_VIS    = 480,
   parameter int unsigned  COL_W    = 10,
   parameter int unsigned  ROW_W    = 10,
   parameter int unsigned  BAND_ROW = 2,
   parameter grid_colour_t C_LEFT   = 8'h38,
   parameter grid_colour_t C_BAND   = 8'hE5,
   parameter grid_colour_t C_RIGHT  = 8'h07,
   parameter grid_colour_t C_FILL   = 8'hCD
) (
   input  logic [COL_W-1:0] col_i,
   input  logic [ROW_W-1:0] row_i,
   output grid_colour_t     colour_o
);

   localparam logic [COL_W-1:0] LEFT_COL  = COL_W'(1);
   localparam logic [COL_W-1:0] RIGHT_COL = COL_W'(H_VIS);
   localparam logic [ROW_W-1:0] BAND_AT   = ROW_W'(BAND_ROW);
   localparam logic [COL_W-1:0] COL_VMAX  = COL_W'(H_VIS);
   localparam logic [ROW_W-1:0] ROW_VMAX  = ROW_W'(V_VIS);

   logic on_screen;
   logic hit_left;
   logic hit_band;
   logic hit_right;

   assign on_screen = (col_i != '0) && (col_i <= COL_VMAX) &&
                      (row_i != '0) && (row_i <= ROW_VMAX);
   assign hit_left  = (col_i == LEFT_COL);
   assign hit_band  = (row_i == BAND_AT);
   assign hit_right = (col_i == RIGHT_COL);

   // precedence: left edge, then band line, then right edge, then fill
   always_comb begin
      if (!on_screen) begin
         colour_o = '0;
      end else if (hit_left) begin
         colour_o = C_LEFT;
      end else if (hit_band) begin
         colour_o = C_BAND;
      end else if (hit_right) begin
         colour_o = C_RIGHT;
      end else begin
         colour_o = C_FILL;
      end
   end

endmodule

// File: rtl/grid_sync_gen.sv
module grid_sync_gen
   import grid_pkg::*;
#(
   parameter int unsigned HS_START = 656,
   parameter int unsigned HS_LEN   = 96,
   parameter int unsigned VS_START = 491,
   parameter int unsigned VS_LEN   = 2,
   parameter int unsigned COL_W    = 10,
   parameter int unsigned ROW_W    = 10
) (
   input  logic [COL_W-1:0] col_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             hs_active_o,
   output logic             vs_active_o
);

   generate
      if (HS_LEN == 0) begin : g_no_hs
         assign hs_active_o = 1'b0;
      end else begin : g_hs
         assign hs_active_o = in_span(int'(col_i), HS_START, HS_LEN);
      end

      if (VS_LEN == 0) begin : g_no_vs
         assign vs_active_o = 1'b0;
      end else begin : g_vs
         assign vs_active_o = in_span(int'(row_i), VS_START, VS_LEN);
      end
   endgenerate

endmodule

// File: rtl/grid_video_timing.sv
module grid_video_timing
   import grid_pkg::*;
#(
   parameter int unsigned  DIV      = 4,
   parameter int unsigned  H_TOTAL  = 800,
   parameter int unsigned  H_VIS    = 640,
   parameter int unsigned  HS_START = 656,
   parameter int unsigned  HS_LEN   = 96,
   parameter int unsigned  V_TOTAL  = 525,
   parameter int unsigned  V_VIS    = 480,
   parameter int unsigned  VS_START = 491,
   parameter int unsigned  VS_LEN   = 2,
   parameter grid_colour_t C_LEFT   = 8'h38,
   parameter grid_colour_t C_BAND   = 8'hE5,
   parameter grid_colour_t C_RIGHT  = 8'h07,
   parameter grid_colour_t C_FILL   = 8'hCD
) (
   input  logic       clk,
   input  logic       rst,
   output logic [7:0] pix_colour,
   output logic       hsync_n,
   output logic       vsync_n
);

   localparam int unsigned COL_W = bits_for(H_TOTAL);
   localparam int unsigned ROW_W = bits_for(V_TOTAL);

   // elaboration-time sanity of the raster geometry
   generate
      if (H_VIS < 2 || H_VIS >= H_TOTAL) begin : g_bad_hvis
         $error("grid_video_timing: H_VIS must lie in [2, H_TOTAL-1]");
      end
      if (V_VIS < 2 || V_VIS >= V_TOTAL) begin : g_bad_vvis
         $error("grid_video_timing: V_VIS must lie in [2, V_TOTAL-1]");
      end
      if (HS_START <= H_VIS || HS_START + HS_LEN - 1 > H_TOTAL) begin : g_bad_hs
         $error("grid_video_timing: horizontal pulse must sit in the blank columns");
      end
      if (VS_START <= V_VIS || VS_START + VS_LEN - 1 > V_TOTAL) begin : g_bad_vs
         $error("grid_video_timing: vertical pulse must sit in the blank lines");
      end
      if (CLR_W != 8) begin : g_bad_clr
         $error("grid_video_timing: colour width must be 8");
      end
   endgenerate

   logic             pix_en;
   logic [COL_W-1:0] col;
   logic [ROW_W-1:0] row;
   grid_colour_t     colour_c;
   logic             hs_act;
   logic             vs_act;

   grid_pace_div #(
      .DIV (DIV)
   ) u_pace (
      .clk  (clk),
      .rst  (rst),
      .en_o (pix_en)
   );

   grid_raster_cnt #(
      .H_TOTAL (H_TOTAL),
      .V_TOTAL (V_TOTAL),
      .COL_W   (COL_W),
      .ROW_W   (ROW_W)
   ) u_raster (
      .clk   (clk),
      .rst   (rst),
      .en_i  (pix_en),
      .col_o (col),
      .row_o (row)
   );

   grid_paint #(
      .H_VIS   (H_VIS),
      .V_VIS   (V_VIS),
      .COL_W   (COL_W),
      .ROW_W   (ROW_W),
      .C_LEFT  (C_LEFT),
      .C_BAND  (C_BAND),
      .C_RIGHT (C_RIGHT),
      .C_FILL  (C_FILL)
   ) u_paint (
      .col_i    (col),
      .row_i    (row),
      .colour_o (colour_c)
   );

   grid_sync_gen #(
      .HS_START (HS_START),
      .HS_LEN   (HS_LEN),
      .VS_START (VS_START),
      .VS_LEN   (VS_LEN),
      .COL_W    (COL_W),
      .ROW_W    (ROW_W)
   ) u_sync (
      .col_i       (col),
      .row_i       (row),
      .hs_active_o (hs_act),
      .vs_active_o (vs_act)
   );

   // one output stage keeps colour and both syncs on the same pixel
   grid_colour_t colour_q;
   logic         hs_n_q;
   logic         vs_n_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         colour_q <= '0;
         hs_n_q   <= 1'b1;
         vs_n_q   <= 1'b1;
      end else begin
         colour_q <= colour_c;
         hs_n_q   <= ~hs_act;
         vs_n_q   <= ~vs_act;
      end
   end

   assign pix_colour = colour_q;
   assign hsync_n    = hs_n_q;
   assign vsync_n    = vs_n_q;

   // syncs only during blanking
   p_hs_blank_r7: assert property (@(posedge clk) disable iff (rst)
      !hsync_n |-> (pix_colour == '0));

   p_vs_blank_r7: assert property (@(posedge clk) disable iff (rst)
      !vsync_n |-> (pix_colour == '0));

   // registered sync reflects the previous clock's column and line
   p_hs_span_r4: assert property (@(posedge clk) disable iff (rst)
      !hsync_n |-> (($past(col) >= COL_W'(HS_START)) &&
                    ($past(col) <= COL_W'(HS_START + HS_LEN - 1))));

   p_vs_span_r5: assert property (@(posedge clk) disable iff (rst)
      !vsync_n |-> (($past(row) >= ROW_W'(VS_START)) &&
                    ($past(row) <= ROW_W'(VS_START + VS_LEN - 1))));

   p_reset_state_r8: assert property (@(posedge clk)
      rst |=> ((pix_colour == '0) && hsync_n && vsync_n));

endmodule

// File: tb/tb_grid_video_timing.sv
module tb_grid_video_timing;

   // reduced raster
   localparam int S_DIV = 4,  S_HT = 20,  S_HV = 12,  S_HS = 14,  S_HL = 3;
   localparam int S_VT = 12,  S_VV = 8,   S_VS = 9,   S_VL = 2;
   // default raster
   localparam int W_DIV = 4,  W_HT = 800, W_HV = 640, W_HS = 656, W_HL = 96;
   localparam int W_VT = 525, W_VV = 480, W_VS = 491, W_VL = 2;

   localparam int RUN_CYCLES = 60000;
   localparam int RST_AT     = 41234;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] s_colour, w_colour;
   logic       s_hs, s_vs, w_hs, w_vs;

   always #4 clk = ~clk;

   grid_video_timing #(
      .DIV(S_DIV), .H_TOTAL(S_HT), .H_VIS(S_HV), .HS_START(S_HS), .HS_LEN(S_HL),
      .V_TOTAL(S_VT), .V_VIS(S_VV), .VS_START(S_VS), .VS_LEN(S_VL)
   ) dut (
      .clk(clk), .rst(rst), .pix_colour(s_colour), .hsync_n(s_hs), .vsync_n(s_vs)
   );

   grid_video_timing dut_wide (
      .clk(clk), .rst(rst), .pix_colour(w_colour), .hsync_n(w_hs), .vsync_n(w_vs)
   );

   typedef struct { int ph; int col; int row; } model_t;

   int n_vec  = 0;
   int n_miss = 0;
   bit done   = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_miss++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic model_t origin();
      model_t m;
      m.ph = 0; m.col = 1; m.row = 1;
      return m;
   endfunction

   function automatic model_t step(input model_t m, input int dv, input int ht, input int vt);
      model_t n = m;
      if (m.ph == dv - 1) begin
         n.ph = 0;
         if (m.col == ht) begin
            n.col = 1;
            n.row = (m.row == vt) ? 1 : m.row + 1;
         end else begin
            n.col = m.col + 1;
         end
      end else begin
         n.ph = m.ph + 1;
      end
      return n;
   endfunction

   function automatic int paint(input int c, input int r, input int hv, input int vv);
      if (c > hv || r > vv) return 'h00;
      if (c == 1)           return 'h38;
      if (r == 2)           return 'hE5;
      if (c == hv)          return 'h07;
      return 'hCD;
   endfunction

   function automatic int in_pulse(input int p, input int lo, input int len);
      return (p >= lo && p < lo + len) ? 0 : 1;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_miss++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   end

   initial begin : main
      model_t ms, mw;
      int s_hs_fall, s_vs_fall, w_hs_fall, s_hs_prev, s_vs_prev, w_hs_prev;
      bit r;
      int ec;
      string tc;

      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R8: reset state of both instances
      chk("R8 reset colour", s_colour, 0);
      chk("R8 reset hsync",  s_hs, 1);
      chk("R8 reset vsync",  s_vs, 1);
      chk("R8 reset colour wide", w_colour, 0);
      chk("R8 reset hsync wide",  w_hs, 1);

      ms = origin();
      mw = origin();
      s_hs_fall = -1; s_vs_fall = -1; w_hs_fall = -1;
      s_hs_prev = 1;  s_vs_prev = 1;  w_hs_prev = 1;

      for (int k = 0; k < RUN_CYCLES; k++) begin
         rst = (k >= RST_AT && k < RST_AT + 3);
         r   = rst;
         @(negedge clk);
         if (r) begin
            ms = origin();
            mw = origin();
            chk("R8 mid reset colour", s_colour, 0);
            chk("R8 mid reset hsync",  s_hs, 1);
            chk("R8 mid reset vsync",  s_vs, 1);
            s_hs_fall = -1; s_vs_fall = -1; w_hs_fall = -1;
         end else begin
            // reduced raster: every output every clock
            ec = paint(ms.col, ms.row, S_HV, S_VV);
            tc = (ec == 0) ? "R7 blank colour" : "R6 grid colour";
            chk(tc, s_colour, ec);
            chk("R4 hsync", s_hs, in_pulse(ms.col, S_HS, S_HL));
            chk("R5 vsync", s_vs, in_pulse(ms.row, S_VS, S_VL));
            // default raster
            ec = paint(mw.col, mw.row, W_HV, W_VV);
            tc = (ec == 0) ? "R7 blank colour wide" : "R6 grid colour wide";
            chk(tc, w_colour, ec);
            chk("R4 hsync wide", w_hs, in_pulse(mw.col, W_HS, W_HL));
            chk("R5 vsync wide", w_vs, in_pulse(mw.row, W_VS, W_VL));
            ms = step(ms, S_DIV, S_HT, S_VT);
            mw = step(mw, W_DIV, W_HT, W_VT);

            // R1/R2: hsync period and pulse width in clocks
            if (s_hs_prev == 1 && s_hs == 0) begin
               if (s_hs_fall >= 0) chk("R2 line period", k - s_hs_fall, S_HT * S_DIV);
               s_hs_fall = k;
            end
            if (s_hs_prev == 0 && s_hs == 1 && s_hs_fall >= 0)
               chk("R1 hsync width clocks", k - s_hs_fall, S_HL * S_DIV);
            // R3: frame period
            if (s_vs_prev == 1 && s_vs == 0) begin
               if (s_vs_fall >= 0) chk("R3 frame period", k - s_vs_fall, S_HT * S_VT * S_DIV);
               s_vs_fall = k;
            end
            if (w_hs_prev == 1 && w_hs == 0) begin
               if (w_hs_fall >= 0) chk("R2 line period wide", k - w_hs_fall, W_HT * W_DIV);
               w_hs_fall = k;
            end
            if (w_hs_prev == 0 && w_hs == 1 && w_hs_fall >= 0)
               chk("R1 hsync width wide", k - w_hs_fall, W_HL * W_DIV);
         end
         s_hs_prev = s_hs;
         s_vs_prev = s_vs;
         w_hs_prev = w_hs;
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

endmodule